// File: doc/BRIEF.md
# Two-Level Return Address Stack

This block keeps return addresses for a small 8-bit microcontroller core. When the core calls a subroutine, or when it accepts an interrupt, the block stores the current return program counter. When the core executes a return from a subroutine or from an interrupt, the block gives that value back as the next program counter. The block has exactly two levels and holds only program counter values. Software cannot reach it: it has no address in data space or in program space, and no data read or write can change its contents or its pointer.

Data comes into the block through two producers. The first is the call strobe. The block never back-pressures a call. A call into a full stack is still accepted, and the oldest saved address is discarded to make room for it. The second producer is the interrupt request, which uses a valid/ready pair: `irq_req` is the valid and `irq_ack` is the ready. The block withholds `irq_ack` while both levels are occupied. It also withholds `irq_ack` in any cycle that carries a call or a return. The request is not consumed while the acknowledge is low, so the interrupt source must keep `irq_req` high. A push happens in the cycle where both `irq_req` and `irq_ack` are high. The return strobe reads out the value on `pop_pc` in the same cycle as the strobe.

Top module: `pc_return_stack`

## Requirements
- R1: After reset, `stk_empty` is 1 and `stk_full` is 0. A return made before any push gives 0 on `pop_pc`.
- R2: A push into a stack that is not full stores `push_pc` on top and grows the depth by one. After two pushes from empty, `stk_full` is 1.
- R3: When the stack is not empty, `ret_valid` shows the most recently stored value on `pop_pc` in the same cycle and shrinks the depth by one. Values come out in last-in, first-out order.
- R4: A call into a full stack discards the oldest entry and the stack stays full. The next two returns give the new address first and then the address that was previously on top.
- R5: While the stack is not full and neither `call_valid` nor `ret_valid` is high, `irq_ack` follows `irq_req` in the same cycle. An acknowledged request pushes `push_pc`.
- R6: While the stack is full, `irq_ack` stays 0 and nothing is pushed. Once a return has freed a level, a request that is still held is acknowledged in the next cycle.
- R7: A return from an empty stack leaves the stack empty and gives the value held in the bottom level on `pop_pc`.
- R8: When `call_valid` and `ret_valid` are high in the same cycle, both are ignored. The depth and the stored values do not change.
- R9: `stk_empty` is 1 exactly when the depth is 0, and `stk_full` is 1 exactly when the depth is 2. The two flags are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_valid | input | 1 | Subroutine call, pushes `push_pc` and is never back-pressured |
| ret_valid | input | 1 | Return from a subroutine or an interrupt, pops the top value |
| irq_req | input | 1 | Pending unmasked interrupt (valid side of the handshake) |
| irq_ack | output | 1 | Interrupt accepted this cycle (ready side of the handshake) |
| push_pc | input | 10 | Return address stored by a push |
| pop_pc | output | 10 | Value on top of the stack, which becomes the next program counter during a return |
| stk_full | output | 1 | Both levels occupied |
| stk_empty | output | 1 | No level occupied |

## Verification
Two results, `irq_ack` and `pop_pc`, depend combinationally on the inputs and on the current state. They are due in the same cycle as the strobe that produces them. The depth flags and the stored values change at the next rising edge. The bench drives its inputs just after the falling edge and samples one time unit later, so it reads the combinational results of that cycle. Its reference model updates only at the rising edge, so the flags and the contents are compared one cycle after the push or pop that changed them. Every cycle is compared against this model, and directed sequences cover the full, empty and clash cases.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  // Operation resolved for the current cycle
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PUSH  = 2'd1,
    OP_POP   = 2'd2,
    OP_CLASH = 2'd3
  } stk_op_e;
endpackage

// File: rtl/rstk_ctl.sv
module rstk_ctl
  import rstk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    call_valid,
  input  logic    ret_valid,
  input  logic    irq_req,
  input  logic    full,
  output logic    irq_ack,
  output stk_op_e op
);
  logic push;

  // An interrupt is taken only into a free level and only in a quiet cycle.
  assign irq_ack = irq_req && !full && !call_valid && !ret_valid;
  assign push    = call_valid || irq_ack;

  always_comb begin
    if (push && ret_valid) op = OP_CLASH;
    else if (push)         op = OP_PUSH;
    else if (ret_valid)    op = OP_POP;
    else                   op = OP_IDLE;
  end

  AST_ACK_HELD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !irq_ack); // R6
  AST_ACK_QUIET_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (irq_req && !call_valid && !ret_valid)); // R5
endmodule

// File: rtl/rstk_ptr.sv
module rstk_ptr
  import rstk_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stk_op_e          op,
  output logic [CNT_W-1:0] cnt,
  output logic             full,
  output logic             empty
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  assign full  = (cnt == FULL_CNT);
  assign empty = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (op == OP_PUSH && !full)  cnt <= cnt + 1'b1;
    else if (op == OP_POP  && !empty) cnt <= cnt - 1'b1;
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R9
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH && !full) |=> cnt == $past(cnt) + 1'b1); // R2
  AST_FULL_CALL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH && full) |=> full); // R4
  AST_EMPTY_POP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP && empty) |=> empty); // R7
  AST_CLASH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLASH) |=> $stable(cnt)); // R8
endmodule

// File: rtl/rstk_store.sv
module rstk_store
  import rstk_pkg::*;
#(
  parameter int PC_W  = 10,
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stk_op_e          op,
  input  logic [CNT_W-1:0] cnt,
  input  logic             full,
  input  logic [PC_W-1:0]  push_pc,
  output logic [PC_W-1:0]  pop_pc
);
  logic [PC_W-1:0] lvl [DEPTH];
  logic [PC_W-1:0] nxt [DEPTH];
  logic            push;

  assign push = (op == OP_PUSH);

  // Level 0 is the bottom. A push into a full stack shifts every level down by one.
  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    if (i == DEPTH - 1) begin : g_top
      assign nxt[i] = (push && (full || cnt == CNT_W'(i))) ? push_pc : lvl[i];
    end else begin : g_low
      assign nxt[i] = !push ? lvl[i] :
                      full  ? lvl[i+1] :
                      (cnt == CNT_W'(i)) ? push_pc : lvl[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) lvl[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) lvl[i] <= nxt[i];
    end
  end

  // Show the top level, or the bottom level when the stack is empty.
  always_comb begin
    pop_pc = lvl[0];
    for (int i = 0; i < DEPTH; i++)
      if (cnt == CNT_W'(i + 1)) pop_pc = lvl[i];
  end

  AST_TOP_IS_LAST_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH) |=> pop_pc == $past(push_pc)); // R2
  AST_CLASH_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLASH) |=> $stable(pop_pc)); // R8
endmodule

// File: rtl/pc_return_stack.sv
module pc_return_stack
  import rstk_pkg::*;
#(
  parameter int PC_W  = 10,
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_valid,
  input  logic            ret_valid,
  input  logic            irq_req,
  output logic            irq_ack,
  input  logic [PC_W-1:0] push_pc,
  output logic [PC_W-1:0] pop_pc,
  output logic            stk_full,
  output logic            stk_empty
);
  stk_op_e          op;
  logic [CNT_W-1:0] cnt;

  rstk_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .call_valid(call_valid), .ret_valid(ret_valid),
    .irq_req(irq_req), .full(stk_full), .irq_ack(irq_ack), .op(op)
  );

  rstk_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .op(op), .cnt(cnt), .full(stk_full), .empty(stk_empty)
  );

  rstk_store #(.PC_W(PC_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .op(op), .cnt(cnt), .full(stk_full),
    .push_pc(push_pc), .pop_pc(pop_pc)
  );

  AST_RESET_EMPTY: assert property (@(posedge clk)
    $rose(rst_n) |-> stk_empty); // R1
endmodule

// File: tb/pc_return_stack_bench.sv
module pc_return_stack_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       call_valid = 1'b0, ret_valid = 1'b0, irq_req = 1'b0;
  logic [9:0] push_pc = '0;
  logic       irq_ack, stk_full, stk_empty;
  logic [9:0] pop_pc;

  int n_chk = 0, n_fail = 0;
  logic [9:0] m [2];
  int         mc = 0;

  always #5 clk = ~clk;

  pc_return_stack u_pc_return_stack (
    .clk(clk), .rst_n(rst_n), .call_valid(call_valid), .ret_valid(ret_valid),
    .irq_req(irq_req), .irq_ack(irq_ack), .push_pc(push_pc), .pop_pc(pop_pc),
    .stk_full(stk_full), .stk_empty(stk_empty)
  );

  function automatic logic exp_ack(logic c, logic r, logic q, int d);
    return q && (d < 2) && !c && !r;
  endfunction

  function automatic logic [9:0] exp_top(int d);
    return (d == 0) ? m[0] : m[d-1];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle, check the combinational results, then update the model at the edge.
  task automatic step(logic c, logic r, logic q, logic [9:0] pc);
    logic a;
    @(negedge clk);
    call_valid = c; ret_valid = r; irq_req = q; push_pc = pc;
    #1;
    chk(stk_empty == (mc == 0), "R9 empty", stk_empty, mc == 0);
    chk(stk_full == (mc == 2), "R9 full", stk_full, mc == 2);
    a = exp_ack(c, r, q, mc);
    chk(irq_ack == a, (mc == 2) ? "R6 ack" : "R5 ack", irq_ack, a);
    if (r && !c)
      chk(pop_pc == exp_top(mc), (mc == 0) ? "R7 pop" : "R3 pop", pop_pc, exp_top(mc));
    if ((c || a) && !r) begin
      if (mc == 2) begin m[0] = m[1]; m[1] = pc; end
      else begin m[mc] = pc; mc++; end
    end else if (r && !c && mc > 0) mc--;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    m[0] = '0; m[1] = '0;
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(stk_empty && !stk_full, "R1 flags", {stk_full, stk_empty}, 1);
    step(0, 1, 0, 10'h000);                  // R1: pop before any push
    chk(pop_pc == 10'd0, "R1 pop", pop_pc, 0);
    step(1, 0, 0, 10'h101);
    step(1, 0, 0, 10'h202);
    step(0, 0, 0, 10'h000);
    chk(stk_full == 1'b1, "R2 full after two", stk_full, 1);
    step(0, 0, 1, 10'h3AA);                  // R6: held off while full
    step(0, 1, 1, 10'h000);                  // return frees a level
    step(0, 0, 1, 10'h155);                  // R6: ack now
    chk(irq_ack == 1'b1, "R6 ack after return", irq_ack, 1);
    step(1, 0, 0, 10'h2F0);                  // R4: call into full
    step(0, 1, 0, 10'h000);
    chk(pop_pc == 10'h2F0, "R4 newest", pop_pc, 10'h2F0);
    step(0, 1, 0, 10'h000);
    chk(pop_pc == 10'h155, "R4 second", pop_pc, 10'h155);
    step(0, 1, 0, 10'h000);                  // R7: empty pop gives bottom
    chk(pop_pc == 10'h155 && stk_empty, "R7 bottom", pop_pc, 10'h155);
    step(1, 0, 0, 10'h0C3);
    step(1, 1, 0, 10'h3FF);                  // R8: clash ignored
    step(0, 0, 0, 10'h000);
    chk(pop_pc == 10'h0C3 && !stk_full && !stk_empty, "R8 clash", pop_pc, 10'h0C3);
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      step(k < 3, (k >= 3 && k < 6), $urandom_range(0, 1) == 1, 10'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule